// File: doc/BRIEF.md
# Mixed-Radix Digit-Reversal Address Generator

This block produces the load-order addresses for an in-place, decimation-in-time FFT built from stages of mixed radix. Software programs a list of up to eight stage radices. Their product is the transform length N. The block then walks a normal-order index from 0 to N-1. For each index it emits the digit-reversed memory address, one per cycle, through a valid/ready output.

Multidimensional transforms use the same datapath. Their elements sit in memory in last-tuple-major order, which gives one linear index. The concatenated stage list of all dimensions therefore describes the whole transform. For example, a 6 by 6 transform whose stage list is 3,2,2,3 is addressed exactly like a 36-point one-dimensional transform. Normal last-tuple-major input maps to digit-reversed first-tuple-major output, so no transposition pass is needed.

Internally the block keeps a mixed-radix digit counter whose least significant digit uses the first stage radix. At load time it precomputes one positional weight per stage for the reversed order. Each address is the weighted sum of the current digits.

Top module: `rmx_digit_rev_agen`

## Requirements
- R1: After reset the outputs are `out_valid`=0 and `done`=0, and `cfg_ready`=1.
- R2: Configuration word format:
  - Slot i occupies `cfg_radix[5*i+4:5*i]` and holds the radix value itself. Slot 0 is the first stage.
  - The word is taken on a cycle with `cfg_valid` and `cfg_ready` both high.
  - N is the product of all slots, and unused slots hold 1.
- R3: The k-th output transfer carries `out_index`=k and the digit-reversed address of k. Write k in mixed radix with slot 0 as the least significant digit, then rebuild the number with slot 0 as the most significant digit. For the list 3,2,2,3, index 1 gives 12, index 3 gives 6 and index 35 gives 35.
- R4: Exactly N transfers occur per run. `done` is high for exactly one cycle: the cycle after the edge that takes the N-th transfer.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_index` hold their values.
- R6: `cfg_ready` is low from the accepting edge until the run completes. A `cfg_valid` seen during that time has no effect on the output sequence.
- R7: A configuration word is discarded if any of the following holds:
  - some slot is outside {1,2,3,4,5,8,16};
  - every slot is 1;
  - N exceeds 2^ADDR_W.

  When a word is discarded, the block stays idle with `cfg_ready`=1 and produces no output. N = 2^ADDR_W is accepted.
- R8: Reversibility. Let addr(k) be the address sequence for a stage list, and addr'(k) the sequence for the reversed list. Then addr'(addr(k)) = k for every k.
- R9: Slots of radix 1 in any position do not change the sequence. For example, 1,4,1,2 gives the same addresses as 4,2.
- R10: With `out_ready` held high, the N transfers occur on N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Block idle and able to take a configuration |
| cfg_radix | input | MAX_STAGES*5 | Packed per-stage radices, slot 0 in the low bits |
| out_valid | output | 1 | Address output valid |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | ADDR_W | Digit-reversed address |
| out_index | output | ADDR_W | Normal-order index of this address |
| done | output | 1 | One-cycle pulse after the last transfer of a run |

## Verification
The hardest situation to reach is a configuration attempt that arrives in the middle of a run while the consumer is stalling. Any leak of the new radices would corrupt only the later addresses.

The stimulus reaches this by offering a different stage list on several consecutive cycles just after a run starts, while a pseudo-random pattern throttles `out_ready`. The scoreboard then compares every address against the original list.

Reversibility and radix-1 transparency are checked by pairing runs and comparing their captured address tables. The length limit is exercised with a run of exactly 2^ADDR_W points and a rejected list one stage longer.

// File: rtl/rmx_pkg.sv
package rmx_pkg;
  localparam int RADIX_W = 5;
  localparam int DIGIT_W = 4;

  typedef enum logic { ST_IDLE, ST_RUN } rmx_state_e;

  function automatic logic radix_legal(input logic [RADIX_W-1:0] r);
    case (r)
      5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd8, 5'd16: radix_legal = 1'b1;
      default:                                   radix_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rmx_cfg_store.sv
module rmx_cfg_store
  import rmx_pkg::*;
#(
  parameter int MAX_STAGES = 8,
  parameter int ADDR_W     = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   load_en,
  input  logic [MAX_STAGES*RADIX_W-1:0]          cfg_word,
  output logic                                   cfg_ok,
  output logic [MAX_STAGES-1:0][RADIX_W-1:0]     radix_q,
  output logic [MAX_STAGES-1:0][ADDR_W-1:0]      weight_q,
  output logic [ADDR_W:0]                        len_q
);
  localparam int PROD_W = MAX_STAGES * DIGIT_W + 1;
  localparam int LEN_W  = ADDR_W + 1;

  logic [MAX_STAGES-1:0][RADIX_W-1:0] slot;
  logic [MAX_STAGES-1:0][ADDR_W-1:0]  weight_d;
  logic [PROD_W-1:0]                  len_d;
  logic                               all_legal;
  logic                               any_real;

  always_comb begin
    logic [PROD_W-1:0] acc;
    acc       = PROD_W'(1);
    all_legal = 1'b1;
    any_real  = 1'b0;
    for (int i = 0; i < MAX_STAGES; i++) begin
      slot[i] = cfg_word[i*RADIX_W +: RADIX_W];
    end
    for (int i = MAX_STAGES - 1; i >= 0; i--) begin
      weight_d[i] = ADDR_W'(acc);
      acc         = acc * PROD_W'(slot[i]);
      if (!radix_legal(slot[i])) all_legal = 1'b0;
      if (slot[i] != RADIX_W'(1)) any_real = 1'b1;
    end
    len_d  = acc;
    cfg_ok = all_legal && any_real && (len_d <= (PROD_W'(1) << ADDR_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAX_STAGES; i++) begin
        radix_q[i]  <= RADIX_W'(1);
        weight_q[i] <= '0;
      end
      len_q <= LEN_W'(1);
    end else if (load_en) begin
      radix_q  <= slot;
      weight_q <= weight_d;
      len_q    <= LEN_W'(len_d);
    end
  end

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(radix_q) && $stable(len_q) && $stable(weight_q)));
endmodule

// File: rtl/rmx_digit_counter.sv
module rmx_digit_counter
  import rmx_pkg::*;
#(
  parameter int MAX_STAGES = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               clear,
  input  logic                               step,
  input  logic [MAX_STAGES-1:0][RADIX_W-1:0] radix_q,
  output logic [MAX_STAGES-1:0][DIGIT_W-1:0] digit_q,
  output logic                               rollover
);
  logic [MAX_STAGES:0] carry;
  assign carry[0] = step;
  assign rollover = carry[MAX_STAGES];

  for (genvar gi = 0; gi < MAX_STAGES; gi++) begin : g_digit
    logic at_top;
    assign at_top          = ({1'b0, digit_q[gi]} == (radix_q[gi] - RADIX_W'(1)));
    assign carry[gi+1]     = carry[gi] && at_top;

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        digit_q[gi] <= '0;
      end else if (carry[gi]) begin
        digit_q[gi] <= at_top ? '0 : digit_q[gi] + DIGIT_W'(1);
      end
    end

    p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, digit_q[gi]} < radix_q[gi]));
  end
endmodule

// File: rtl/rmx_addr_assemble.sv
module rmx_addr_assemble
  import rmx_pkg::*;
#(
  parameter int MAX_STAGES = 8,
  parameter int ADDR_W     = 16
) (
  input  logic [MAX_STAGES-1:0][DIGIT_W-1:0] digit_q,
  input  logic [MAX_STAGES-1:0][ADDR_W-1:0]  weight_q,
  output logic [ADDR_W-1:0]                  addr
);
  logic [MAX_STAGES-1:0][ADDR_W-1:0] term;

  for (genvar gi = 0; gi < MAX_STAGES; gi++) begin : g_term
    assign term[gi] = ADDR_W'(digit_q[gi]) * weight_q[gi];
  end

  always_comb begin
    addr = '0;
    for (int i = 0; i < MAX_STAGES; i++) begin
      addr = addr + term[i];
    end
  end
endmodule

// File: rtl/rmx_digit_rev_agen.sv
module rmx_digit_rev_agen
  import rmx_pkg::*;
#(
  parameter int MAX_STAGES = 8,
  parameter int ADDR_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_valid,
  output logic                          cfg_ready,
  input  logic [MAX_STAGES*RADIX_W-1:0] cfg_radix,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [ADDR_W-1:0]             out_addr,
  output logic [ADDR_W-1:0]             out_index,
  output logic                          done
);
  localparam int LEN_W = ADDR_W + 1;

  rmx_state_e                         state;
  logic                               issuing;
  logic [ADDR_W-1:0]                  idx;
  logic                               cfg_ok;
  logic                               accept;
  logic                               adv;
  logic                               last_idx;
  logic                               finish;
  logic                               rollover;
  logic [ADDR_W-1:0]                  asm_addr;
  logic [MAX_STAGES-1:0][RADIX_W-1:0] radix_q;
  logic [MAX_STAGES-1:0][ADDR_W-1:0]  weight_q;
  logic [MAX_STAGES-1:0][DIGIT_W-1:0] digit_q;
  logic [ADDR_W:0]                    len_q;

  assign cfg_ready = (state == ST_IDLE);
  assign accept    = cfg_valid && cfg_ready && cfg_ok;
  assign adv       = (state == ST_RUN) && issuing && (!out_valid || out_ready);
  assign last_idx  = ({1'b0, idx} == (len_q - LEN_W'(1)));
  assign finish    = (state == ST_RUN) && !issuing && out_valid && out_ready;

  rmx_cfg_store #(.MAX_STAGES(MAX_STAGES), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .load_en(accept), .cfg_word(cfg_radix),
    .cfg_ok(cfg_ok), .radix_q(radix_q), .weight_q(weight_q), .len_q(len_q)
  );

  rmx_digit_counter #(.MAX_STAGES(MAX_STAGES)) u_cnt (
    .clk(clk), .rst(rst), .clear(accept), .step(adv),
    .radix_q(radix_q), .digit_q(digit_q), .rollover(rollover)
  );

  rmx_addr_assemble #(.MAX_STAGES(MAX_STAGES), .ADDR_W(ADDR_W)) u_asm (
    .digit_q(digit_q), .weight_q(weight_q), .addr(asm_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      issuing   <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_index <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state   <= ST_RUN;
        issuing <= 1'b1;
        idx     <= '0;
      end
      if (adv) begin
        out_addr  <= asm_addr;
        out_index <= idx;
        idx       <= idx + ADDR_W'(1);
        out_valid <= 1'b1;
        if (last_idx) issuing <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (finish) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_index)));

  p_done_after_xfer_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, out_addr} < len_q));

  p_roll_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    rollover |-> last_idx);

  p_busy_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cfg_ready);
endmodule

// File: tb/rmx_digit_rev_agen_test.sv
`timescale 1ns/1ps
module rmx_digit_rev_agen_test;
  localparam int MS = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [MS*5-1:0] cfg_word = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [AW-1:0] out_index;
  logic          done;

  rmx_digit_rev_agen #(.MAX_STAGES(MS), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_radix(cfg_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_index(out_index), .done(done)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;
  int exp_addr[$];
  int exp_idx[$];
  int cap[4096];
  int keep_a[4096];
  int xfer, first_cyc, last_cyc;
  bit run_done, done_due, hold_pend, rnd_ready;
  int h_addr, h_idx;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rev_of(input int n, input int r[8]);
    int a = 0;
    int k = n;
    for (int i = 0; i < 8; i++) begin
      a = a * r[i] + (k % r[i]);
      k = k / r[i];
    end
    return a;
  endfunction

  function automatic logic [MS*5-1:0] pack(input int r[8]);
    logic [MS*5-1:0] w = '0;
    for (int i = 0; i < 8; i++) w[i*5 +: 5] = 5'(r[i]);
    return w;
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (hold_pend)
        chk(out_valid && out_addr == AW'(h_addr) && out_index == AW'(h_idx),
            "R5 hold", int'(out_addr), h_addr);
      hold_pend = out_valid && !out_ready;
      h_addr = int'(out_addr);
      h_idx  = int'(out_index);
      if (done_due || done) begin
        chk(done == done_due, "R4 done pulse", int'(done), int'(done_due));
        if (done) run_done = 1;
      end
      done_due = 0;
      if (out_valid && out_ready) begin
        xfer++;
        if (xfer == 1) first_cyc = cyc;
        last_cyc = cyc;
        if (exp_addr.size() == 0) begin
          chk(0, "R4 extra output", int'(out_index), -1);
        end else begin
          int ea, ei;
          ea = exp_addr.pop_front();
          ei = exp_idx.pop_front();
          chk(out_addr == AW'(ea) && out_index == AW'(ei), "R3 address", int'(out_addr), ea);
          if (int'(out_index) < 4096) cap[out_index] = int'(out_addr);
          if (exp_addr.size() == 0) done_due = 1;
        end
      end
    end
  end

  task automatic run_cfg(input int r[8], input bit rnd, input bit poke);
    int n = 1;
    int other[8] = '{5, 5, 1, 1, 1, 1, 1, 1};
    for (int i = 0; i < 8; i++) n = n * r[i];
    for (int k = 0; k < n; k++) begin
      exp_addr.push_back(rev_of(k, r));
      exp_idx.push_back(k);
    end
    xfer = 0;
    run_done = 0;
    rnd_ready = rnd;
    @(posedge clk); #1;
    cfg_word = pack(r);
    cfg_valid = 1;
    do @(negedge clk); while (!cfg_ready);
    @(posedge clk); #1;
    cfg_valid = 0;
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        cfg_word = pack(other);
        cfg_valid = 1;
        @(negedge clk);
        chk(!cfg_ready, "R6 busy ready", int'(cfg_ready), 0);
        @(posedge clk); #1;
      end
      cfg_valid = 0;
    end
    while (!run_done) @(negedge clk);
    chk(xfer == n, "R4 transfer count", xfer, n);
    @(negedge clk);
    chk(cfg_ready && !out_valid, "R6 ready after run", int'(cfg_ready), 1);
  endtask

  task automatic try_bad(input int r[8], input string what);
    @(posedge clk); #1;
    cfg_word = pack(r);
    cfg_valid = 1;
    @(posedge clk); #1;
    cfg_valid = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!out_valid && cfg_ready && !done, {"R7 ", what}, int'(out_valid), 0);
    end
  endtask

  initial begin
    int l3223[8] = '{3, 2, 2, 3, 1, 1, 1, 1};
    int l234[8]  = '{2, 3, 4, 1, 1, 1, 1, 1};
    int l432[8]  = '{4, 3, 2, 1, 1, 1, 1, 1};
    int l1412[8] = '{1, 4, 1, 2, 1, 1, 1, 1};
    int l42[8]   = '{4, 2, 1, 1, 1, 1, 1, 1};
    int lmax[8]  = '{16, 16, 16, 16, 1, 1, 1, 1};
    int lover[8] = '{16, 16, 16, 16, 2, 1, 1, 1};
    int lsix[8]  = '{6, 2, 1, 1, 1, 1, 1, 1};
    int lzero[8] = '{3, 0, 1, 1, 1, 1, 1, 1};
    int lones[8] = '{1, 1, 1, 1, 1, 1, 1, 1};
    int l5816[8] = '{5, 8, 16, 1, 1, 1, 1, 1};
    bit ok;

    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid && !done && cfg_ready, "R1 reset state", int'(out_valid), 0);

    // R2 R3 R10: 36-point list, no stalls
    run_cfg(l3223, 0, 0);
    chk(cap[1] == 12, "R3 index1", cap[1], 12);
    chk(cap[3] == 6, "R3 index3", cap[3], 6);
    chk(cap[35] == 35, "R3 index35", cap[35], 35);
    chk(last_cyc - first_cyc == 35, "R10 back-to-back", last_cyc - first_cyc, 35);

    // R5 R6: same list with throttled consumer and config pokes while busy
    run_cfg(l3223, 1, 1);

    // R8 reversibility
    run_cfg(l234, 1, 0);
    for (int k = 0; k < 24; k++) keep_a[k] = cap[k];
    run_cfg(l432, 0, 0);
    ok = 1;
    for (int k = 0; k < 24; k++) if (cap[keep_a[k]] != k) ok = 0;
    chk(ok, "R8 reversal round trip", int'(ok), 1);

    // R9 radix-1 transparency
    run_cfg(l1412, 0, 0);
    for (int k = 0; k < 8; k++) keep_a[k] = cap[k];
    run_cfg(l42, 1, 0);
    ok = 1;
    for (int k = 0; k < 8; k++) if (cap[k] != keep_a[k]) ok = 0;
    chk(ok, "R9 unit slots", int'(ok), 1);

    // R2 other legal radices
    run_cfg(l5816, 1, 0);

    // R7 rejections
    try_bad(lsix, "radix 6");
    try_bad(lzero, "radix 0");
    try_bad(lones, "all ones");
    try_bad(lover, "too long");

    // R7 boundary: exactly 2^ADDR_W points accepted
    run_cfg(lmax, 0, 0);
    chk(cap[1] == 4096, "R3 max list index1", cap[1], 4096);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule